// File: doc/BRIEF.md
# Single-Block SHA-1 Hash Core

This core hashes exactly one 512-bit block with the SHA-1 compression function. It performs one round per clock and finishes in 80 rounds. The caller pads the message and presents the whole block together with a one-cycle `start`. The core works from its own copy of the block, so the caller may change the block input while the hash runs. There is no chaining between blocks, and padding is the caller's job.

The `mode` input is sampled together with the block and chooses how the result is formed. In standard mode the initial chaining value is added to the working variables after the last round. The digest is then presented as a, b, c, d, e, each word big-endian. In the alternate mode that final addition is skipped, and the 20 result bytes are emitted in fully reversed order. The result is therefore e, d, c, b, a, with each word little-endian. Some challenge/response authentication schemes compute their message codes in this form.

The result is registered. It stays on `digest` until the next computation completes. `busy` reports that a hash is running, and `done` pulses for one cycle when a new digest appears.

Top module: `sha1_block_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core clears itself: after that edge `busy`=0, `done`=0 and `digest`=0.
- R2: A `start` seen at an edge with `busy` low is accepted. `busy` is high for exactly the next 80 cycles. `done` is high for exactly one cycle, in the cycle right after the last busy cycle, and never while `busy` is high.
- R3: With `mode`=0, `digest` is the standard SHA-1 result of the block, including the initial-value addition. Word a is in bits [159:128] and word e is in bits [31:0], each word big-endian. For example, the padded block for "abc" gives a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R4: With `mode`=1, no initial value is added after round 79. `digest` is the byte reversal of {a,b,c,d,e}: byte 0 of e sits in bits [159:152] and byte 3 of a sits in bits [7:0].
- R5: Message word 0 is taken from `block[511:480]` and word 15 from `block[31:0]`. Words 16 to 79 are the XOR of w[i-3], w[i-8], w[i-14] and w[i-16], rotated left by one. The round functions and constants are those of standard SHA-1, and the working variables start from 67452301h, EFCDAB89h, 98BADCFEh, 10325476h, C3D2E1F0h.
- R6: `start` while `busy` is high is ignored. The running hash, its timing and its result are unchanged.
- R7: `block` and `mode` are sampled only at the accepting edge. Changes to them while `busy` is high have no effect on the result.
- R8: `digest` changes only at the edge that raises `done`. Otherwise it holds its value.
- R9: A `start` held high during the `done` cycle is accepted at once. Consecutive results from a continuously held `start` are therefore 81 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to hash `block`; accepted only when idle |
| mode | input | 1 | 0 = standard result, 1 = no final addition and byte-reversed result |
| block | input | 512 | Padded message block, word 0 in the top 32 bits |
| busy | output | 1 | A hash is in progress |
| done | output | 1 | One-cycle pulse when `digest` is updated |
| digest | output | 160 | Registered 160-bit result |

## Verification
The assertions rely on the caller treating `busy` as the only back-pressure. The core takes a request whenever it is idle. The run-length property also counts on reset being held for at least two edges before it is released, so that the hold check starts from a settled `digest`.

The stimulus changes inputs only just after the rising edge and holds reset for several cycles. It sends `start` pulses at arbitrary points, including while busy, in the completion cycle, and held high continuously. Through all of this it also changes `block` and `mode` while a hash is running, to show that only the accepting edge matters.

// File: rtl/sha1_core_pkg.sv
// Shared constants, types and helper functions for the single-block SHA-1 core.
// Assumes 32-bit words and a fixed 80-round, 16-word-block algorithm.
package sha1_core_pkg;
    localparam int WORD_W       = 32;
    localparam int BLOCK_WORDS  = 16;
    localparam int STATE_WORDS  = 5;
    localparam int ROUNDS       = 80;
    localparam int PHASE_LEN    = 20;
    localparam int RND_W        = $clog2(ROUNDS);
    localparam int IDX_W        = $clog2(BLOCK_WORDS);
    localparam int BLOCK_W      = WORD_W * BLOCK_WORDS;
    localparam int DIGEST_W     = WORD_W * STATE_WORDS;
    localparam int DIGEST_BYTES = DIGEST_W / 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RND_W-1:0]  rnd_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } state_t;

    localparam state_t INIT_STATE = '{
        a: 32'h67452301,
        b: 32'hEFCDAB89,
        c: 32'h98BADCFE,
        d: 32'h10325476,
        e: 32'hC3D2E1F0
    };

    localparam rnd_t PH1_START  = rnd_t'(PHASE_LEN);
    localparam rnd_t PH2_START  = rnd_t'(2 * PHASE_LEN);
    localparam rnd_t PH3_START  = rnd_t'(3 * PHASE_LEN);
    localparam rnd_t LAST_RND   = rnd_t'(ROUNDS - 1);
    localparam rnd_t EXPAND_RND = rnd_t'(BLOCK_WORDS);

    // Rotate a word left by n bits.
    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Non-linear mixing function of the round phase.
    function automatic word_t mix_fn(input rnd_t t, input word_t b, input word_t c, input word_t d);
        if (t < PH1_START)      return (b & c) | (~b & d);
        else if (t < PH2_START) return b ^ c ^ d;
        else if (t < PH3_START) return (b & c) | (b & d) | (c & d);
        else                    return b ^ c ^ d;
    endfunction

    // Additive constant of the round phase.
    function automatic word_t phase_const(input rnd_t t);
        if (t < PH1_START)      return 32'h5A827999;
        else if (t < PH2_START) return 32'h6ED9EBA1;
        else if (t < PH3_START) return 32'h8F1BBCDC;
        else                    return 32'hCA62C1D6;
    endfunction
endpackage

// File: rtl/sha1_msg_sched.sv
// Rolling message schedule: holds the 16 most recent schedule words in a
// circular bank. It loads the block on `load` and provides the word for the current
// round. From round 16 on it writes each expanded word back into the slot of
// the word it replaces. Assumes rounds advance by one per `step`.
module sha1_msg_sched
    import sha1_core_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BLOCK_W-1:0] block,
    input  logic               step,
    input  rnd_t               rnd,
    output word_t              w_cur
);
    word_t bank [BLOCK_WORDS];
    word_t expand;
    idx_t  slot;
    logic  expanding;

    assign slot      = rnd[IDX_W-1:0];
    assign expanding = (rnd >= EXPAND_RND);

    // Form the next schedule word from the four taps in the circular bank.
    always_comb begin
        expand = rotl(bank[slot + idx_t'(BLOCK_WORDS - 3)]
                    ^ bank[slot + idx_t'(BLOCK_WORDS - 8)]
                    ^ bank[slot + idx_t'(BLOCK_WORDS - 14)]
                    ^ bank[slot], 1);
        w_cur  = expanding ? expand : bank[slot];
    end

    for (genvar g = 0; g < BLOCK_WORDS; g++) begin : g_slot
        word_t slot_q;

        // Load from the block, or take the expanded word when this slot is due.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (load)
                slot_q <= block[BLOCK_W-1-g*WORD_W -: WORD_W];
            else if (step && expanding && (slot == idx_t'(g)))
                slot_q <= expand;
        end

        assign bank[g] = slot_q;
    end
endmodule

// File: rtl/sha1_round_fn.sv
// One SHA-1 round, purely combinational: takes the working variables, the
// round number and the schedule word, and returns the updated variables.
module sha1_round_fn
    import sha1_core_pkg::*;
(
    input  state_t cur,
    input  rnd_t   rnd,
    input  word_t  w,
    output state_t nxt
);
    word_t temp;

    // Compute the new 'a' and shift the remaining variables down.
    always_comb begin
        temp  = rotl(cur.a, 5) + mix_fn(rnd, cur.b, cur.c, cur.d)
              + cur.e + phase_const(rnd) + w;
        nxt.a = temp;
        nxt.b = cur.a;
        nxt.c = rotl(cur.b, 30);
        nxt.d = cur.c;
        nxt.e = cur.d;
    end
endmodule

// File: rtl/sha1_seq_ctrl.sv
// Sequencer: accepts a request only when idle, then counts 80 rounds. It
// flags the last round and pulses `done` one cycle after it.
module sha1_seq_ctrl
    import sha1_core_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic step,
    output logic last,
    output rnd_t rnd,
    output logic busy,
    output logic done
);
    logic busy_q;
    logic done_q;
    rnd_t rnd_q;

    assign accept = start && !busy_q;
    assign step   = busy_q;
    assign last   = busy_q && (rnd_q == LAST_RND);
    assign rnd    = rnd_q;
    assign busy   = busy_q;
    assign done   = done_q;

    // Advance the round counter and the busy/done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rnd_q  <= '0;
        end else begin
            done_q <= last;
            if (accept) begin
                busy_q <= 1'b1;
                rnd_q  <= '0;
            end else if (busy_q) begin
                if (last) begin
                    busy_q <= 1'b0;
                    rnd_q  <= '0;
                end else begin
                    rnd_q <= rnd_q + rnd_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sha1_block_core.sv
// Single-block SHA-1 core. Hashes one caller-padded 512-bit block at one
// round per clock. Mode 0 gives the standard result (initial value added,
// a..e big-endian). Mode 1 skips the addition and byte-reverses the 160-bit
// result. Assumes the caller waits for `busy` low before expecting a request to take.
module sha1_block_core
    import sha1_core_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode,
    input  logic [511:0]        block,
    output logic                busy,
    output logic                done,
    output logic [159:0]        digest
);
    logic   accept, step, last;
    rnd_t   rnd;
    word_t  w_cur;
    state_t state_q, state_nxt;
    logic   mode_q;
    logic [DIGEST_W-1:0] raw_res, std_res, alt_res, digest_q;

    sha1_seq_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .step   (step),
        .last   (last),
        .rnd    (rnd),
        .busy   (busy),
        .done   (done)
    );

    sha1_msg_sched u_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .block (block),
        .step  (step),
        .rnd   (rnd),
        .w_cur (w_cur)
    );

    sha1_round_fn u_round (
        .cur (state_q),
        .rnd (rnd),
        .w   (w_cur),
        .nxt (state_nxt)
    );

    assign raw_res = state_nxt;

    // Standard result: add the initial chaining value word by word.
    for (genvar j = 0; j < STATE_WORDS; j++) begin : g_ffwd
        localparam int LSB = j * WORD_W;
        assign std_res[LSB +: WORD_W] = raw_res[LSB +: WORD_W] + INIT_STATE[LSB +: WORD_W];
    end

    // Alternate result: full byte reversal of the round output.
    for (genvar i = 0; i < DIGEST_BYTES; i++) begin : g_brev
        assign alt_res[i*8 +: 8] = raw_res[(DIGEST_BYTES-1-i)*8 +: 8];
    end

    // Working variables: seed on accept, one round per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else if (accept)
            state_q <= INIT_STATE;
        else if (step)
            state_q <= state_nxt;
    end

    // Capture the output convention together with the block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (accept)
            mode_q <= mode;
    end

    // Register the formatted result at the last round.
    always_ff @(posedge clk) begin
        if (!rst_n)
            digest_q <= '0;
        else if (last)
            digest_q <= mode_q ? alt_res : std_res;
    end

    assign digest = digest_q;
endmodule

// File: rtl/sha1_block_core_chk.sv
// Protocol checker for sha1_block_core: run length, the done pulse, request
// acceptance and result hold. Attached to every instance through bind.
module sha1_block_core_chk
    import sha1_core_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [159:0] digest
);
    localparam int CNT_W = $clog2(ROUNDS + 1);
    logic [CNT_W-1:0] run_cnt;

    // Count consecutive busy cycles seen at clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (busy)
            run_cnt <= run_cnt + CNT_W'(1);
        else
            run_cnt <= '0;
    end

    p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == CNT_W'(ROUNDS)));

    p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < CNT_W'(ROUNDS)));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && run_cnt == '0));

    p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && run_cnt < CNT_W'(ROUNDS - 1)) |=> busy);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(digest));
endmodule

bind sha1_block_core sha1_block_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .digest (digest)
);

// File: tb/test_sha1_block_core.sv
// Bench for sha1_block_core: a behavioural next-cycle model compared on every
// clock, plus directed checks of known digests and handshake corners.
module test_sha1_block_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [511:0] block = '0;
    logic         busy, done;
    logic [159:0] digest;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5ns clk = ~clk;

    sha1_block_core i_sha1_block_core (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .block(block), .busy(busy), .done(done), .digest(digest)
    );

    localparam logic [159:0] IV_WORDS = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

    function automatic logic [31:0] rol(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [159:0] byte_rev(input logic [159:0] x);
        logic [159:0] r;
        for (int i = 0; i < 20; i++) r[i*8 +: 8] = x[(19-i)*8 +: 8];
        return r;
    endfunction

    // Alternate result derived from a standard one: subtract IV, reverse bytes.
    function automatic logic [159:0] alt_from_std(input logic [159:0] s);
        logic [159:0] raw;
        for (int j = 0; j < 5; j++) raw[j*32 +: 32] = s[j*32 +: 32] - IV_WORDS[j*32 +: 32];
        return byte_rev(raw);
    endfunction

    // Reference hash of one block (R3, R4, R5).
    function automatic logic [159:0] ref_hash(input logic [511:0] b, input logic m);
        logic [31:0] w [80];
        logic [31:0] a, bb, c, d, e, f, k, t;
        for (int i = 0; i < 16; i++) w[i] = b[511 - 32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rol(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        {a, bb, c, d, e} = IV_WORDS;
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (bb & c) | (~bb & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = bb ^ c ^ d;                    k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (bb & c) | (bb & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = bb ^ c ^ d;                    k = 32'hCA62C1D6; end
            t = rol(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rol(bb, 30); bb = a; a = t;
        end
        if (m) return byte_rev({a, bb, c, d, e});
        return {a + 32'h67452301, bb + 32'hEFCDAB89, c + 32'h98BADCFE,
                d + 32'h10325476, e + 32'hC3D2E1F0};
    endfunction

    task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle model: compare at the falling edge, then predict the next edge.
    bit           m_valid = 0;
    bit           m_rst = 0;
    bit           m_busy = 0, m_done = 0;
    logic [159:0] m_dig = '0;
    int           m_cnt = 0;
    logic [511:0] m_blk;
    logic         m_mode;

    always @(negedge clk) begin
        if (m_valid && !finished) begin
            chk(m_rst ? "R1 busy" : "R2 busy", {159'd0, busy}, {159'd0, m_busy});
            chk(m_rst ? "R1 done" : "R2 done", {159'd0, done}, {159'd0, m_done});
            chk(m_rst ? "R1 digest" : "R8 digest", digest, m_dig);
        end
        m_valid = 1;
        m_rst   = !rst_n;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_dig = '0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 80) begin
                    m_busy = 0; m_done = 1;
                    m_dig = ref_hash(m_blk, m_mode);
                end
            end else if (start) begin
                m_busy = 1; m_cnt = 0; m_blk = block; m_mode = mode;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1ns;
    endtask

    // Run one hash; returns busy-cycle count and the digest at done.
    task automatic run_one(input logic [511:0] b, input logic m,
                           output int nbusy, output logic [159:0] res);
        block = b; mode = m; start = 1'b1;
        tick();
        start = 1'b0;
        nbusy = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (busy) nbusy++;
            if (done) break;
        end
        res = digest;
        tick();
    endtask

    logic [511:0] abc_blk;
    logic [159:0] abc_std;

    initial begin
        int nb;
        logic [159:0] res, held;
        logic [511:0] rb;
        abc_blk = '0;
        abc_blk[511:480] = 32'h61626380;
        abc_blk[31:0]    = 32'h00000018;
        abc_std = 160'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d;

        repeat (4) tick();
        @(negedge clk);
        chk("R1 reset busy/done", {158'd0, busy, done}, '0);
        chk("R1 reset digest", digest, '0);
        tick();
        rst_n = 1'b1;
        tick();

        // R3: known vector, standard form; R2: run length
        run_one(abc_blk, 1'b0, nb, res);
        chk("R3 abc standard", res, abc_std);
        chk("R2 busy cycles", 160'(nb), 160'd80);

        // R4: known vector, alternate form
        run_one(abc_blk, 1'b1, nb, res);
        chk("R4 abc alternate", res, alt_from_std(abc_std));

        // R5: assorted blocks in both modes
        for (int n = 0; n < 6; n++) begin
            for (int j = 0; j < 16; j++) rb[j*32 +: 32] = $urandom();
            if (n == 0) rb = '0;
            if (n == 1) rb = '1;
            run_one(rb, n[0], nb, res);
            chk("R5 block digest", res, ref_hash(rb, n[0]));
        end

        // R6 and R7: start, block and mode changes during a run
        rb = {16{32'h0badcafe}};
        block = rb; mode = 1'b0; start = 1'b1;
        tick();
        start = 1'b0;
        repeat (10) tick();
        block = ~rb; mode = 1'b1; start = 1'b1;
        tick();
        start = 1'b0;
        repeat (30) tick();
        block = abc_blk; mode = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done) break;
        end
        chk("R6 R7 start/inputs ignored while busy", digest, ref_hash(rb, 1'b0));
        held = digest;
        tick();

        // R8: result holds while idle
        repeat (20) tick();
        @(negedge clk);
        chk("R8 digest held idle", digest, held);
        tick();

        // R9: start held high, back-to-back runs 81 cycles apart
        begin
            int first, second, cyc;
            first = -1; second = -1; cyc = 0;
            block = abc_blk; mode = 1'b0; start = 1'b1;
            tick();
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                cyc++;
                if (done) begin
                    if (first < 0) first = cyc;
                    else if (second < 0) second = cyc;
                end
                if (first >= 0 && cyc == first + 1)
                    chk("R9 busy after done", {159'd0, busy}, {159'd0, 1'b1});
            end
            start = 1'b0;
            chk("R9 result spacing", 160'(second - first), 160'd81);
        end
        repeat (100) tick();

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #2ms;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule